// File: doc/BRIEF.md
# Reduce Instruction Descriptor Validator

This block checks a 64-byte reduction instruction descriptor before the descriptor goes to an execution engine. The descriptor arrives as a byte stream, one byte on each beat where `in_valid` is high, starting at offset 0. Multi-byte fields are little-endian. The block keeps only the bytes that any check or decoded output needs: the opcode, the parameter block at offsets 32 to 43, and the element counts of the source and destination patterns. The header remainder, the event words, the start addresses and the strides are not stored.

On the cycle after the beat that carries byte 63, the block raises `verdict_valid` for exactly one cycle. In that cycle it gives the accept flag, a reason code, the dispatch bit (0 for the arithmetic handler, 1 for the bit-vector handler), and the decoded op, axis, dtypes, channel count and scale. The checks follow a fixed priority, and the lowest-numbered failing check sets the reason.

The control is a three-state machine:
- `ST_IDLE` waits for byte 0. A valid beat captures byte 0 and moves to `ST_RECV`.
- `ST_RECV` counts bytes 1 to 63. The valid beat carrying byte 63 moves to `ST_VERDICT`.
- `ST_VERDICT` presents the verdict for one cycle, ignores any input beat, and always returns to `ST_IDLE`.

Top module: `rdv_validator`

## Requirements
- R1: Only beats with `in_valid` high are counted, so idle cycles inside a descriptor are skipped. `verdict_valid` is high for exactly one cycle, the cycle after the beat that carries byte 63.
- R2: The opcode (byte 0) must be 0x7C (arithmetic) or 0x7D (bit-vector), otherwise reason 1. `to_bitvec` is 1 exactly when the opcode is 0x7D.
- R3: Reserved bytes 37, 38 and 39 must all be zero, otherwise reason 2.
- R4: An input dtype (byte 32) of 0x0B is rejected with reason 3. An output dtype (byte 33) of 0x0B is accepted. A channel count (byte 34) of zero is also rejected with reason 3.
- R5: With opcode 0x7C the op (byte 35) must be 0 to 2. With opcode 0x7D it must be 3 to 5. Otherwise reason 4.
- R6: The axis (byte 36) must be 0 or 1, otherwise reason 5.
- R7: With axis 0, each of the four destination element counts (16-bit little-endian at bytes 56, 58, 60, 62) must equal 1, otherwise reason 6.
- R8: With axis 1, the product of the destination counts must equal the product of the four source counts (16-bit little-endian at bytes 24, 26, 28, 30), otherwise reason 6.
- R9: When several checks fail, the reason is the lowest failing code in the order 1 to 6. `verdict_ok` is 1 exactly when the reason is 0.
- R10: During the verdict cycle the outputs carry the op, axis, input dtype, output dtype, channel count and scale (32-bit little-endian at bytes 40 to 43). The scale reads 0 when `to_bitvec` is 1. While `verdict_valid` is low, every output is 0.
- R11: A beat presented during the verdict cycle is ignored. A new descriptor may start on the cycle after the verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | `in_byte` carries the next descriptor byte |
| in_byte | input | 8 | Descriptor byte |
| verdict_valid | output | 1 | One-cycle verdict strobe |
| verdict_ok | output | 1 | Descriptor accepted |
| reason | output | 3 | Reject code, 0 when accepted |
| to_bitvec | output | 1 | Dispatch: 1 selects the bit-vector handler |
| op_code | output | 8 | Decoded reduce op |
| axis_sel | output | 8 | Decoded reduce axis |
| src_type | output | 8 | Decoded input dtype |
| dst_type | output | 8 | Decoded output dtype |
| chan_cnt | output | 8 | Decoded active channel count |
| scale_word | output | 32 | Scale, zero on the bit-vector path |

## Verification
The assertions assume that each descriptor delivers exactly 64 valid beats before the next one starts. They also assume that the counts in any axis-1 descriptor are small enough for both products to fit in 64 bits. The stimulus task always sends whole descriptors and picks counts whose products are a few hundred at most. Junk beats go only into the verdict cycle, where the block is required to drop them, and idle gaps go only between valid beats.

// File: rtl/rdv_pkg.sv
package rdv_pkg;
    localparam int DESC_BYTES   = 64;
    localparam int OFS_OPCODE   = 0;
    localparam int OFS_SRC_CNT  = 24;
    localparam int OFS_PARAMS   = 32;
    localparam int PARAMS_BYTES = 12;
    localparam int OFS_DST_CNT  = 56;

    localparam logic [7:0] OPC_ARITH       = 8'h7C;
    localparam logic [7:0] OPC_BITVEC      = 8'h7D;
    localparam logic [7:0] DTYPE_FP32_RND  = 8'h0B;
    localparam logic [7:0] OP_LAST_ARITH   = 8'd2;
    localparam logic [7:0] OP_FIRST_BITVEC = 8'd3;
    localparam logic [7:0] OP_LAST_BITVEC  = 8'd5;
    localparam logic [7:0] AXIS_LAST       = 8'd1;
    localparam logic [7:0] AXIS_COLLAPSE   = 8'd0;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_RECV    = 2'd1,
        ST_VERDICT = 2'd2
    } rdv_state_e;

    typedef enum logic [2:0] {
        RSN_NONE     = 3'd0,
        RSN_OPCODE   = 3'd1,
        RSN_RESERVED = 3'd2,
        RSN_DTYPE    = 3'd3,
        RSN_OP_CLASS = 3'd4,
        RSN_AXIS     = 3'd5,
        RSN_SHAPE    = 3'd6
    } rdv_reason_e;
endpackage

// File: rtl/rdv_field_cap.sv
module rdv_field_cap #(
    parameter int OFS   = 0,
    parameter int NB    = 1,
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_en,
    input  logic [IDX_W-1:0] idx,
    input  logic [7:0]       din,
    output logic [8*NB-1:0]  q
);
    logic [7:0] byte_q [NB];

    for (genvar i = 0; i < NB; i++) begin : g_byte
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                byte_q[i] <= '0;
            end else if (cap_en && (idx == IDX_W'(OFS + i))) begin
                byte_q[i] <= din;
            end
        end
        // byte i of the field lands at bits 8i, giving little-endian order
        assign q[8*i +: 8] = byte_q[i];
    end
endmodule

// File: rtl/rdv_shape_chk.sv
module rdv_shape_chk #(
    parameter int NUM_DIMS = 4,
    parameter int CNT_W    = 16
) (
    input  logic [NUM_DIMS*CNT_W-1:0] src_cnt,
    input  logic [NUM_DIMS*CNT_W-1:0] dst_cnt,
    output logic                      dst_unit,
    output logic                      prod_match
);
    localparam int PW = NUM_DIMS * CNT_W;

    logic [PW-1:0] src_prod;
    logic [PW-1:0] dst_prod;

    always_comb begin
        src_prod = PW'(1);
        dst_prod = PW'(1);
        dst_unit = 1'b1;
        for (int d = 0; d < NUM_DIMS; d++) begin
            src_prod = src_prod * PW'(src_cnt[d*CNT_W +: CNT_W]);
            dst_prod = dst_prod * PW'(dst_cnt[d*CNT_W +: CNT_W]);
            if (dst_cnt[d*CNT_W +: CNT_W] != CNT_W'(1)) begin
                dst_unit = 1'b0;
            end
        end
        prod_match = (src_prod == dst_prod);
    end
endmodule

// File: rtl/rdv_judge.sv
module rdv_judge
    import rdv_pkg::*;
(
    input  logic [7:0]  opcode,
    input  logic [7:0]  in_dtype,
    input  logic [7:0]  chan,
    input  logic [7:0]  op,
    input  logic [7:0]  axis,
    input  logic [23:0] rsv,
    input  logic        dst_unit,
    input  logic        prod_match,
    output rdv_reason_e reason
);
    logic is_arith;
    logic is_bitvec;
    logic op_bad;

    always_comb begin
        is_arith  = (opcode == OPC_ARITH);
        is_bitvec = (opcode == OPC_BITVEC);
        op_bad    = (is_arith && (op > OP_LAST_ARITH)) ||
                    (is_bitvec && ((op < OP_FIRST_BITVEC) || (op > OP_LAST_BITVEC)));

        if (!is_arith && !is_bitvec) begin
            reason = RSN_OPCODE;
        end else if (rsv != '0) begin
            reason = RSN_RESERVED;
        end else if ((in_dtype == DTYPE_FP32_RND) || (chan == '0)) begin
            reason = RSN_DTYPE;
        end else if (op_bad) begin
            reason = RSN_OP_CLASS;
        end else if (axis > AXIS_LAST) begin
            reason = RSN_AXIS;
        end else if ((axis == AXIS_COLLAPSE) ? !dst_unit : !prod_match) begin
            reason = RSN_SHAPE;
        end else begin
            reason = RSN_NONE;
        end
    end
endmodule

// File: rtl/rdv_validator.sv
module rdv_validator
    import rdv_pkg::*;
#(
    parameter int NUM_DIMS = 4,
    parameter int CNT_W    = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [7:0]  in_byte,
    output logic        verdict_valid,
    output logic        verdict_ok,
    output logic [2:0]  reason,
    output logic        to_bitvec,
    output logic [7:0]  op_code,
    output logic [7:0]  axis_sel,
    output logic [7:0]  src_type,
    output logic [7:0]  dst_type,
    output logic [7:0]  chan_cnt,
    output logic [31:0] scale_word
);
    localparam int IDX_W     = $clog2(DESC_BYTES);
    localparam int CNT_BYTES = NUM_DIMS * CNT_W / 8;
    localparam int CW        = NUM_DIMS * CNT_W;
    // byte positions inside the captured parameter block
    localparam int PB_IDT    = 0;
    localparam int PB_ODT    = 1;
    localparam int PB_CHAN   = 2;
    localparam int PB_OP     = 3;
    localparam int PB_AXIS   = 4;
    localparam int PB_RSV    = 5;
    localparam int PB_SCALE  = 8;

    rdv_state_e state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic             cap_en;

    logic [7:0]                  opcode_q;
    logic [8*PARAMS_BYTES-1:0]   params_q;
    logic [CW-1:0]               src_cnt_q;
    logic [CW-1:0]               dst_cnt_q;
    logic                        dst_unit;
    logic                        prod_match;
    rdv_reason_e                 rsn;

    assign cap_en = in_valid && (state_q != ST_VERDICT);

    rdv_field_cap #(.OFS(OFS_OPCODE), .NB(1), .IDX_W(IDX_W)) u_cap_opc (
        .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .idx(idx_q), .din(in_byte), .q(opcode_q)
    );
    rdv_field_cap #(.OFS(OFS_PARAMS), .NB(PARAMS_BYTES), .IDX_W(IDX_W)) u_cap_par (
        .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .idx(idx_q), .din(in_byte), .q(params_q)
    );
    rdv_field_cap #(.OFS(OFS_SRC_CNT), .NB(CNT_BYTES), .IDX_W(IDX_W)) u_cap_src (
        .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .idx(idx_q), .din(in_byte), .q(src_cnt_q)
    );
    rdv_field_cap #(.OFS(OFS_DST_CNT), .NB(CNT_BYTES), .IDX_W(IDX_W)) u_cap_dst (
        .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .idx(idx_q), .din(in_byte), .q(dst_cnt_q)
    );

    rdv_shape_chk #(.NUM_DIMS(NUM_DIMS), .CNT_W(CNT_W)) u_shape (
        .src_cnt(src_cnt_q), .dst_cnt(dst_cnt_q), .dst_unit(dst_unit), .prod_match(prod_match)
    );

    rdv_judge u_judge (
        .opcode    (opcode_q),
        .in_dtype  (params_q[8*PB_IDT  +: 8]),
        .chan      (params_q[8*PB_CHAN +: 8]),
        .op        (params_q[8*PB_OP   +: 8]),
        .axis      (params_q[8*PB_AXIS +: 8]),
        .rsv       (params_q[8*PB_RSV  +: 24]),
        .dst_unit  (dst_unit),
        .prod_match(prod_match),
        .reason    (rsn)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            ST_IDLE: begin
                if (in_valid) begin
                    state_d = ST_RECV;
                    idx_d   = IDX_W'(1);
                end
            end
            ST_RECV: begin
                if (in_valid) begin
                    if (idx_q == IDX_W'(DESC_BYTES - 1)) begin
                        state_d = ST_VERDICT;
                        idx_d   = '0;
                    end else begin
                        idx_d = idx_q + IDX_W'(1);
                    end
                end
            end
            ST_VERDICT: begin
                state_d = ST_IDLE;
                idx_d   = '0;
            end
            default: begin
                state_d = ST_IDLE;
                idx_d   = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        verdict_valid = 1'b0;
        verdict_ok    = 1'b0;
        reason        = '0;
        to_bitvec     = 1'b0;
        op_code       = '0;
        axis_sel      = '0;
        src_type      = '0;
        dst_type      = '0;
        chan_cnt      = '0;
        scale_word    = '0;
        unique case (state_q)
            ST_VERDICT: begin
                verdict_valid = 1'b1;
                verdict_ok    = (rsn == RSN_NONE);
                reason        = rsn;
                to_bitvec     = (opcode_q == OPC_BITVEC);
                op_code       = params_q[8*PB_OP   +: 8];
                axis_sel      = params_q[8*PB_AXIS +: 8];
                src_type      = params_q[8*PB_IDT  +: 8];
                dst_type      = params_q[8*PB_ODT  +: 8];
                chan_cnt      = params_q[8*PB_CHAN +: 8];
                scale_word    = (opcode_q == OPC_BITVEC) ? '0 : params_q[8*PB_SCALE +: 32];
            end
            ST_IDLE, ST_RECV: begin
            end
            default: begin
            end
        endcase
    end
endmodule

// File: rtl/rdv_checker.sv
module rdv_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        verdict_valid,
    input logic        verdict_ok,
    input logic [2:0]  reason,
    input logic        to_bitvec,
    input logic [7:0]  op_code,
    input logic [7:0]  axis_sel,
    input logic [7:0]  src_type,
    input logic [7:0]  chan_cnt,
    input logic [31:0] scale_word
);
    // R1
    verdict_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        verdict_valid |=> !verdict_valid);

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !verdict_valid |-> (!verdict_ok && reason == 3'd0 && !to_bitvec &&
                            op_code == 8'd0 && scale_word == 32'd0));

    // R9
    ok_reason_chk: assert property (@(posedge clk) disable iff (!rst_n)
        verdict_valid |-> (verdict_ok == (reason == 3'd0)));

    // R10
    bv_scale_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (verdict_valid && to_bitvec) |-> (scale_word == 32'd0));

    // R5
    ok_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        verdict_ok |-> (to_bitvec ? (op_code >= 8'd3 && op_code <= 8'd5) : (op_code <= 8'd2)));

    // R4
    ok_dtype_chk: assert property (@(posedge clk) disable iff (!rst_n)
        verdict_ok |-> (src_type != 8'h0B && chan_cnt != 8'd0));

    // R6
    ok_axis_chk: assert property (@(posedge clk) disable iff (!rst_n)
        verdict_ok |-> (axis_sel <= 8'd1));

    // R9
    reason_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reason <= 3'd6);
endmodule

bind rdv_validator rdv_checker chk_i (
    .clk(clk), .rst_n(rst_n), .verdict_valid(verdict_valid), .verdict_ok(verdict_ok),
    .reason(reason), .to_bitvec(to_bitvec), .op_code(op_code), .axis_sel(axis_sel),
    .src_type(src_type), .chan_cnt(chan_cnt), .scale_word(scale_word)
);

// File: tb/rdv_validator_tb_top.sv
module rdv_validator_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic        verdict_valid, verdict_ok, to_bitvec;
    logic [2:0]  reason;
    logic [7:0]  op_code, axis_sel, src_type, dst_type, chan_cnt;
    logic [31:0] scale_word;

    always #2 clk = ~clk;

    rdv_validator dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .verdict_valid(verdict_valid), .verdict_ok(verdict_ok), .reason(reason),
        .to_bitvec(to_bitvec), .op_code(op_code), .axis_sel(axis_sel),
        .src_type(src_type), .dst_type(dst_type), .chan_cnt(chan_cnt), .scale_word(scale_word)
    );

    typedef struct {
        int     due;
        int     rsn;
        int     bv;
        int     op;
        int     axis;
        int     idt;
        int     odt;
        int     chan;
        longint scale;
    } exp_t;

    exp_t   eq[$];
    string  tq[$];
    int     cyc = 0;
    int     n_checks = 0;
    int     n_fails = 0;
    bit     finished = 1'b0;
    logic [7:0] d [64];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic cmp(input string tag, input string what, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic put16(input int ofs, input int v);
        d[ofs]   = 8'(v);
        d[ofs+1] = 8'(v >> 8);
    endtask

    task automatic base_desc(input int opc, input int op, input int axis);
        for (int i = 0; i < 64; i++) d[i] = 8'(i * 7 + 3);
        d[0] = 8'(opc); d[1] = 8'd16; d[2] = 8'd0; d[3] = 8'd0;
        d[32] = 8'd2; d[33] = 8'd2; d[34] = 8'd8; d[35] = 8'(op); d[36] = 8'(axis);
        d[37] = 8'd0; d[38] = 8'd0; d[39] = 8'd0;
        d[40] = 8'h00; d[41] = 8'h00; d[42] = 8'h80; d[43] = 8'h3F;
        put16(24, 8); put16(26, 4); put16(28, 1); put16(30, 1);
        if (axis == 0) begin
            put16(56, 1); put16(58, 1); put16(60, 1); put16(62, 1);
        end else begin
            put16(56, 4); put16(58, 8); put16(60, 1); put16(62, 1);
        end
    endtask

    function automatic int cnt16(input int ofs);
        return int'(d[ofs]) + 256 * int'(d[ofs+1]);
    endfunction

    // behavioural model of the verdict, from the requirements
    function automatic exp_t model();
        exp_t   e;
        longint ps = 1, pd = 1;
        bit     unit = 1'b1;
        int     opc = int'(d[0]);
        int     op  = int'(d[35]);
        for (int k = 0; k < 4; k++) begin
            ps = ps * cnt16(24 + 2*k);
            pd = pd * cnt16(56 + 2*k);
            if (cnt16(56 + 2*k) != 1) unit = 1'b0;
        end
        e.due = 0;
        if (opc != 124 && opc != 125) e.rsn = 1;
        else if (d[37] != 0 || d[38] != 0 || d[39] != 0) e.rsn = 2;
        else if (d[32] == 8'h0B || d[34] == 0) e.rsn = 3;
        else if ((opc == 124 && op > 2) || (opc == 125 && (op < 3 || op > 5))) e.rsn = 4;
        else if (d[36] > 1) e.rsn = 5;
        else if (d[36] == 0 && !unit) e.rsn = 6;
        else if (d[36] == 1 && ps != pd) e.rsn = 6;
        else e.rsn = 0;
        e.bv   = (opc == 125) ? 1 : 0;
        e.op   = op;
        e.axis = int'(d[36]);
        e.idt  = int'(d[32]);
        e.odt  = int'(d[33]);
        e.chan = int'(d[34]);
        e.scale = (opc == 125) ? 0 :
                  longint'({d[43], d[42], d[41], d[40]});
        return e;
    endfunction

    // gap: idle cycle before every gap-th byte (0 = none); junk: beat during the verdict cycle
    task automatic send(input string tag, input int gap, input bit junk);
        exp_t e;
        for (int i = 0; i < 64; i++) begin
            if (gap > 0 && i > 0 && (i % gap) == 0) begin
                @(posedge clk); #1;
                in_valid = 1'b0; in_byte = 8'hA5;
            end
            @(posedge clk); #1;
            in_valid = 1'b1; in_byte = d[i];
        end
        e = model();
        e.due = cyc + 1;
        eq.push_back(e);
        tq.push_back(tag);
        @(posedge clk); #1;
        in_valid = junk; in_byte = 8'h7C;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            in_valid = 1'b0;
        end
    endtask

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (eq.size() > 0 && eq[0].due == cyc) begin
                exp_t  e;
                string t;
                e = eq.pop_front();
                t = tq.pop_front();
                cmp(t, "verdict_valid R1", longint'(verdict_valid), 1);
                cmp(t, "reason R9", longint'(reason), e.rsn);
                cmp(t, "verdict_ok R9", longint'(verdict_ok), (e.rsn == 0) ? 1 : 0);
                cmp(t, "to_bitvec R2", longint'(to_bitvec), e.bv);
                cmp(t, "op_code R10", longint'(op_code), e.op);
                cmp(t, "axis_sel R10", longint'(axis_sel), e.axis);
                cmp(t, "src_type R10", longint'(src_type), e.idt);
                cmp(t, "dst_type R10", longint'(dst_type), e.odt);
                cmp(t, "chan_cnt R10", longint'(chan_cnt), e.chan);
                cmp(t, "scale_word R10", longint'(scale_word), e.scale);
            end else begin
                cmp("R1/R10 idle", "verdict_valid", longint'(verdict_valid), 0);
                cmp("R1/R10 idle", "outputs", longint'({verdict_ok, reason, to_bitvec, op_code, scale_word}), 0);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10 reset state
        cmp("R10 reset", "verdict_valid", longint'(verdict_valid), 0);
        cmp("R10 reset", "outputs", longint'({verdict_ok, reason, to_bitvec, op_code, axis_sel,
                                               src_type, dst_type, chan_cnt, scale_word}), 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        idle(2);

        // R1 R10: legal arith add, collapse axis
        base_desc(124, 0, 0); send("R1/R10 arith add", 0, 1'b0);
        // R8 R10: legal bitvec xor, per-partition axis, scale suppressed
        base_desc(125, 5, 1); put16(24, 2); put16(26, 3); put16(28, 4);
        put16(56, 4); put16(58, 6); put16(60, 1); put16(62, 1);
        send("R8/R10 bitvec xor", 0, 1'b0);
        // R2 R9: bad opcode beats reserved fault
        base_desc(123, 0, 0); d[38] = 8'd1; send("R2/R9 bad opcode", 0, 1'b0);
        // R3
        base_desc(124, 1, 0); d[39] = 8'h40; send("R3 reserved", 0, 1'b0);
        // R4: input fp32 round-mode rejected, output allowed
        base_desc(124, 2, 0); d[32] = 8'h0B; send("R4 in dtype", 0, 1'b0);
        base_desc(124, 2, 0); d[33] = 8'h0B; send("R4 out dtype ok", 0, 1'b0);
        base_desc(125, 3, 0); d[34] = 8'd0; d[35] = 8'd9; send("R4/R9 zero chan", 0, 1'b0);
        // R5
        base_desc(124, 3, 0); send("R5 arith op3", 0, 1'b0);
        base_desc(125, 2, 0); send("R5 bitvec op2", 0, 1'b0);
        base_desc(125, 6, 0); send("R5 bitvec op6", 0, 1'b0);
        base_desc(125, 4, 1); send("R5 bitvec and", 0, 1'b0);
        // R6
        base_desc(124, 0, 2); d[57] = 8'd3; send("R6/R9 axis2", 0, 1'b0);
        // R7
        base_desc(124, 1, 0); put16(60, 2); send("R7 dst count", 0, 1'b0);
        base_desc(124, 1, 0); put16(56, 256); send("R7 little-endian count", 0, 1'b0);
        // R8
        base_desc(125, 3, 1); put16(62, 2); send("R8 product mismatch", 0, 1'b0);
        base_desc(124, 2, 1); put16(56, 32); put16(58, 1); send("R8 reshaped ok", 0, 1'b0);
        // R1: idle gaps inside the stream
        base_desc(124, 2, 0); d[40] = 8'h11; d[41] = 8'h22; d[42] = 8'h33; d[43] = 8'h44;
        send("R1 gaps", 5, 1'b0);
        // R11: junk in the verdict cycle, then back-to-back descriptors
        base_desc(124, 0, 0); send("R11 junk dropped", 0, 1'b1);
        base_desc(125, 4, 0); send("R11 back to back", 3, 1'b1);
        base_desc(124, 1, 1); send("R11 back to back 2", 0, 1'b0);
        idle(4);

        cmp("R1 pending", "queue", longint'(eq.size()), 0);
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end
endmodule